// File: doc/BRIEF.md
# Microprogram Sequencer with Dispatch Tables

This block is the control unit of a multicycle datapath, implemented as a microprogram. A 4-bit micro-address register selects one word from a built-in microcode store. Each word carries 16 datapath control bits and a 2-bit sequencing field. The control bits drive the datapath during the current cycle. The sequencing field tells the address-select logic where to go next. It can step to the following word, jump back to the fetch word, or consult one of two lookup tables indexed by the 6-bit instruction opcode.

The first lookup table runs after decode and sends each supported instruction class to its first execution word. The second table runs after the shared address computation and splits loads from stores. An opcode that a table does not list returns the sequencer to fetch. The datapath outside this block is expected to hold the opcode steady while the instruction executes. The opcode is read only in the two cycles whose sequencing field selects a table.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the micro-address becomes 0. At address 0 `ctrl` equals 16'h9408.
- R2: The sequencing field of each word selects the next address: 2'b11 steps to the current address plus one, 2'b00 goes to 0, 2'b01 uses table one, 2'b10 uses table two. Addresses 4, 5, 7, 8 and 9 use 2'b00, so they return to 0 on the next edge.
- R3: Addresses 0, 3 and 6 use 2'b11, so their successors are 1, 4 and 7.
- R4: Address 1 uses table one, which maps opcode 6'h23 and 6'h2B to 2, 6'h00 to 6, 6'h04 to 8 and 6'h02 to 9.
- R5: Address 2 uses table two, which maps 6'h23 to 3 and 6'h2B to 5.
- R6: Any opcode that the active table does not list sends the sequencer to address 0. This covers every opcode other than the five at address 1, and every opcode other than 6'h23 and 6'h2B at address 2.
- R7: The `ctrl` value depends only on the current address: 0:9408, 1:0018, 2:0014, 3:3000, 4:0202, 5:2800, 6:0044, 7:0003, 8:40A4, 9:8100 (hex). Bit 12 (memory read) and bit 11 (memory write) are never both set.
- R8: The micro-address advances on every rising edge. An opcode change at an address that does not use a table has no effect on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the current instruction |
| ctrl | output | 16 | Datapath control bits of the current word |
| upc | output | 4 | Current micro-address |

## Verification
All 64 opcodes are driven through a full pass from fetch back to fetch. At every step, the micro-address and the control word are checked against a path computed from the table mappings. A table with a missing or swapped entry would send an instruction to the wrong routine, or leave an unlisted opcode stuck in execution words instead of returning to fetch. The opcode is also changed in mid-flight. A change just before the second table must drop the sequencer to fetch. A change at a step-only address must leave the path alone; a design that read the opcode at every step would branch early. A reset asserted in the middle of a load must land on fetch. A sequencer that ignored reset while running, or restarted at the wrong word, would fail this check.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int UPC_W  = 4,
  parameter int OP_W   = 6,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  output logic [CTRL_W-1:0] ctrl,
  output logic [UPC_W-1:0]  upc
);
  localparam int WORD_W = CTRL_W + 2;

  localparam logic [1:0] SQ_FETCH = 2'b00;
  localparam logic [1:0] SQ_TAB1  = 2'b01;
  localparam logic [1:0] SQ_TAB2  = 2'b10;
  localparam logic [1:0] SQ_STEP  = 2'b11;

  localparam logic [OP_W-1:0] OP_ALU   = OP_W'(6'h00);
  localparam logic [OP_W-1:0] OP_JMP   = OP_W'(6'h02);
  localparam logic [OP_W-1:0] OP_BRANCH = OP_W'(6'h04);
  localparam logic [OP_W-1:0] OP_LOAD  = OP_W'(6'h23);
  localparam logic [OP_W-1:0] OP_STORE = OP_W'(6'h2B);

  localparam logic [UPC_W-1:0] UA_FETCH  = UPC_W'(0);
  localparam logic [UPC_W-1:0] UA_MADDR  = UPC_W'(2);
  localparam logic [UPC_W-1:0] UA_LDRD   = UPC_W'(3);
  localparam logic [UPC_W-1:0] UA_STWR   = UPC_W'(5);
  localparam logic [UPC_W-1:0] UA_ALUEX  = UPC_W'(6);
  localparam logic [UPC_W-1:0] UA_BRANCH = UPC_W'(8);
  localparam logic [UPC_W-1:0] UA_JMP    = UPC_W'(9);

  function automatic logic [WORD_W-1:0] ustore(input logic [UPC_W-1:0] a);
    case (a)
      UPC_W'(0): ustore = {SQ_STEP,  CTRL_W'(16'h9408)};
      UPC_W'(1): ustore = {SQ_TAB1,  CTRL_W'(16'h0018)};
      UPC_W'(2): ustore = {SQ_TAB2,  CTRL_W'(16'h0014)};
      UPC_W'(3): ustore = {SQ_STEP,  CTRL_W'(16'h3000)};
      UPC_W'(4): ustore = {SQ_FETCH, CTRL_W'(16'h0202)};
      UPC_W'(5): ustore = {SQ_FETCH, CTRL_W'(16'h2800)};
      UPC_W'(6): ustore = {SQ_STEP,  CTRL_W'(16'h0044)};
      UPC_W'(7): ustore = {SQ_FETCH, CTRL_W'(16'h0003)};
      UPC_W'(8): ustore = {SQ_FETCH, CTRL_W'(16'h40A4)};
      UPC_W'(9): ustore = {SQ_FETCH, CTRL_W'(16'h8100)};
      default:   ustore = {SQ_FETCH, CTRL_W'(0)};
    endcase
  endfunction

  function automatic logic [UPC_W-1:0] tab1(input logic [OP_W-1:0] op);
    case (op)
      OP_LOAD, OP_STORE: tab1 = UA_MADDR;
      OP_ALU:            tab1 = UA_ALUEX;
      OP_BRANCH:         tab1 = UA_BRANCH;
      OP_JMP:            tab1 = UA_JMP;
      default:           tab1 = UA_FETCH;
    endcase
  endfunction

  function automatic logic [UPC_W-1:0] tab2(input logic [OP_W-1:0] op);
    case (op)
      OP_LOAD:  tab2 = UA_LDRD;
      OP_STORE: tab2 = UA_STWR;
      default:  tab2 = UA_FETCH;
    endcase
  endfunction

  logic [WORD_W-1:0] word;
  logic [1:0]        seq;
  logic [UPC_W-1:0]  upc_nxt;

  assign word = ustore(upc);
  assign seq  = word[WORD_W-1 -: 2];
  assign ctrl = word[CTRL_W-1:0];

  always_comb begin
    case (seq)
      SQ_STEP: upc_nxt = upc + UPC_W'(1);
      SQ_TAB1: upc_nxt = tab1(opcode);
      SQ_TAB2: upc_nxt = tab2(opcode);
      default: upc_nxt = UA_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= UA_FETCH;
    else     upc <= upc_nxt;
  end
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int UPC_W  = 4,
  parameter int OP_W   = 6,
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   opcode,
  input logic [CTRL_W-1:0] ctrl,
  input logic [UPC_W-1:0]  upc
);
  AST_RESET_FETCH: assert property (@(posedge clk) rst |=> upc == UPC_W'(0)); // R1

  AST_RETURN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (upc inside {UPC_W'(4), UPC_W'(5), UPC_W'(7), UPC_W'(8), UPC_W'(9)}) |=> upc == UPC_W'(0)); // R2

  AST_STEP_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
    upc == UPC_W'(0) |=> upc == UPC_W'(1)); // R3

  AST_TAB1_TARGET: assert property (@(posedge clk) disable iff (rst)
    upc == UPC_W'(1) |=> (upc inside {UPC_W'(0), UPC_W'(2), UPC_W'(6), UPC_W'(8), UPC_W'(9)})); // R4

  AST_TAB2_TARGET: assert property (@(posedge clk) disable iff (rst)
    upc == UPC_W'(2) |=> (upc inside {UPC_W'(0), UPC_W'(3), UPC_W'(5)})); // R5

  AST_UNLISTED_OP: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(1) && !(opcode inside {OP_W'(6'h00), OP_W'(6'h02), OP_W'(6'h04), OP_W'(6'h23), OP_W'(6'h2B)}))
    |=> upc == UPC_W'(0)); // R6

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl[12:11]) <= 1); // R7
endmodule

bind useq_ctrl useq_ctrl_chk #(.UPC_W(UPC_W), .OP_W(OP_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .ctrl(ctrl), .upc(upc)
);

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'h00;
  logic [15:0] ctrl;
  logic [3:0]  upc;
  int total = 0;
  int bad = 0;

  useq_ctrl u0 (.clk(clk), .rst(rst), .opcode(opcode), .ctrl(ctrl), .upc(upc));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] exp_ctrl(input int a);
    case (a)
      0: return 16'h9408; 1: return 16'h0018; 2: return 16'h0014;
      3: return 16'h3000; 4: return 16'h0202; 5: return 16'h2800;
      6: return 16'h0044; 7: return 16'h0003; 8: return 16'h40A4;
      9: return 16'h8100; default: return 16'h0000;
    endcase
  endfunction

  function automatic int exp_next(input int a, input logic [5:0] op);
    case (a)
      0, 3, 6: return a + 1;
      1: case (op)
           6'h23, 6'h2B: return 2;
           6'h00: return 6;
           6'h04: return 8;
           6'h02: return 9;
           default: return 0;
         endcase
      2: return (op == 6'h23) ? 3 : (op == 6'h2B) ? 5 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", upc, 0);
    chk("R1 reset ctrl", ctrl, 16'h9408);
    rst = 1'b0;

    // R2 R3 R4 R5 R6 R7: every opcode, full path
    for (int op = 0; op < 64; op++) begin
      opcode = 6'(op);
      a = 0;
      for (int s = 0; s < 8; s++) begin
        chk("R7 ctrl", ctrl, exp_ctrl(a));
        a = exp_next(a, 6'(op));
        tick();
        chk("R4 R5 R6 path", upc, a);
        if (a == 0) break;
      end
      chk("R2 back at fetch", upc, 0);
    end

    // R6: opcode becomes unlisted just before the second table
    opcode = 6'h23;
    tick(); tick();
    chk("R5 at addr computation", upc, 2);
    opcode = 6'h00;
    tick();
    chk("R6 table two unlisted", upc, 0);

    // R8: opcode change at a step-only address has no effect
    opcode = 6'h00;
    tick(); tick();
    chk("R4 alu exec", upc, 6);
    opcode = 6'h23;
    tick();
    chk("R8 step ignores opcode", upc, 7);
    chk("R7 ctrl at 7", ctrl, 16'h0003);
    tick();
    chk("R8 returns", upc, 0);

    // R1: reset in the middle of a load
    opcode = 6'h23;
    tick(); tick(); tick();
    chk("R3 load read", upc, 3);
    rst = 1'b1;
    tick();
    chk("R1 mid reset addr", upc, 0);
    tick();
    chk("R1 held in reset", upc, 0);
    chk("R1 ctrl in reset", ctrl, 16'h9408);
    rst = 1'b0;
    tick();
    chk("R3 step after reset", upc, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule